// File: doc/BRIEF.md
# Security Code Guard with Attempt Counter

This block decides whether the surrounding memory controller may write or erase. It holds a multi-byte security code at the top of the address space, with an attempt counter one address below the code bytes. A caller spends an attempt by clearing one set bit of the counter. The caller then presents the code bytes one at a time, lowest code address first. When every byte matches, the counter is refilled and the write-enable output rises. It stays high until the next session reset.

Each wrong byte uses up the attempt it was armed with. When the counter has no set bits left and no attempt is pending, the block reports itself locked. From then on it accepts no verification, so writing is barred for good. Two resets are kept apart. `rst_ni` ends a session and drops write permission. `nv_rst_ni` puts the counter, the code bytes and their protect flags back to their shipped state. The counter and code storage stand in for non-volatile cells, so a session reset leaves them untouched.

Commands arrive already decoded, as an opcode, an address and a data byte. Serial framing and the main data array lie outside this block.

Top module: `sec_code_guard`

## Requirements
- R1: While `rst_ni` is low and after it is released, `wr_en_o` is 0 and no attempt is pending. A session reset leaves `err_cnt_o`, the code bytes and the protect flags unchanged.
- R2: With `nv_rst_ni` low, the counter becomes 0xFF and the code bytes return to `CODE_INIT` (byte 0 = bits 7:0 = 0x5A, byte 1 = 0xA5). Both protect flags clear and `locked_o` is 0.
- R3: A write (opcode 1 or 2) to the counter address 0x3FD while `wr_en_o` is 0 stores `counter & data`, so bits can only be cleared. The new value shows on `err_cnt_o` one cycle after the command. If the write clears at least one set bit, an attempt becomes pending.
- R4: A verify command (opcode 0) is ignored unless an attempt is pending.
- R5: A pending attempt succeeds when code byte 0 (address 0x3FE) matches and then code byte 1 (address 0x3FF) matches. One cycle after the second command, `wr_en_o` is 1 and `err_cnt_o` is 0xFF.
- R6: Any of the following ends the pending attempt, resets the byte sequence and leaves the counter as it is: a mismatching byte, or byte 1 presented before byte 0 has matched. Verifying again needs a fresh counter write.
- R7: `locked_o` is 1 exactly when the counter is 0, no attempt is pending and `wr_en_o` is 0. Once set, it stays set through session resets, and verify commands have no effect. The eighth attempt, armed by clearing the last bit, may still succeed.
- R8: While `wr_en_o` is 1, a counter write stores the data byte as given, so bits may be set as well as cleared.
- R9: While `wr_en_o` is 1, a write to a code address whose protect flag is clear replaces that byte. Opcode 2 also sets the byte's protect flag. A write to a code address has no effect when that byte is protected or `wr_en_o` is 0.
- R10: Opcode 3 has no effect, and a command to an address outside 0x3FD..0x3FF has no effect. The same holds for a verify aimed at the counter address.
- R11: While `wr_en_o` is 1, verify commands are ignored and `wr_en_o` stays 1 until `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous session reset |
| nv_rst_ni | input | 1 | Active-low asynchronous reset of counter, code bytes and protect flags to shipped state |
| cmd_valid_i | input | 1 | Command strobe, one command per cycle |
| cmd_op_i | input | 2 | 0 verify, 1 write, 2 write and protect, 3 no operation |
| cmd_addr_i | input | ADDR_W | Command address |
| cmd_data_i | input | DATA_W | Compare byte, counter mask or new code byte |
| wr_en_o | output | 1 | Write and erase permitted |
| locked_o | output | 1 | No attempts left |
| err_cnt_o | output | DATA_W | Current attempt counter |

## Verification
A wrong pending-attempt flag or a wrong byte-sequence index shows up at the ports only through later commands. Examples are a correct code that fails to raise `wr_en_o`, or `locked_o` arriving one attempt early or late. Every command is therefore followed, one cycle later, by a comparison of all three outputs against an independent model. Stored code bytes and protect flags are observed only by a later unlock attempt, so rewrites are always followed by a reset and a fresh verification.

// File: rtl/sec_pkg.sv
package sec_pkg;
  typedef enum logic [1:0] {
    OP_VERIFY     = 2'd0,
    OP_WRITE      = 2'd1,
    OP_WRITE_PROT = 2'd2,
    OP_NOP        = 2'd3
  } sec_op_e;
endpackage

// File: rtl/sec_cmd_decode.sv
module sec_cmd_decode
  import sec_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int NUM_CODE = 2
) (
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [ADDR_W-1:0]   cmd_addr_i,
  output logic                cnt_wr_o,
  output logic [NUM_CODE-1:0] vfy_sel_o,
  output logic [NUM_CODE-1:0] code_wr_o,
  output logic                code_prot_o
);
  localparam logic [ADDR_W-1:0] TOP_A = '1;
  localparam logic [ADDR_W-1:0] CNT_A = TOP_A - ADDR_W'(NUM_CODE);

  sec_op_e op;
  logic    wr_op, vfy_op;

  assign op          = sec_op_e'(cmd_op_i);
  assign wr_op       = cmd_valid_i && (op == OP_WRITE || op == OP_WRITE_PROT);
  assign vfy_op      = cmd_valid_i && (op == OP_VERIFY);
  assign cnt_wr_o    = wr_op && (cmd_addr_i == CNT_A);
  assign code_prot_o = (op == OP_WRITE_PROT);

  for (genvar g = 0; g < NUM_CODE; g++) begin : g_code_addr
    logic hit;
    assign hit          = (cmd_addr_i == CNT_A + ADDR_W'(g + 1));
    assign vfy_sel_o[g] = vfy_op && hit;
    assign code_wr_o[g] = wr_op && hit;
  end
endmodule

// File: rtl/sec_nv_store.sv
module sec_nv_store #(
  parameter int                         DATA_W    = 8,
  parameter int                         NUM_CODE  = 2,
  parameter logic [NUM_CODE*DATA_W-1:0] CODE_INIT = 16'hA55A
) (
  input  logic                               clk_i,
  input  logic                               nv_rst_ni,
  input  logic                               we_i,
  input  logic                               restore_i,
  input  logic                               cnt_wr_i,
  input  logic [NUM_CODE-1:0]                code_wr_i,
  input  logic                               code_prot_i,
  input  logic [DATA_W-1:0]                  data_i,
  output logic [DATA_W-1:0]                  cnt_o,
  output logic [NUM_CODE-1:0][DATA_W-1:0]    code_o
);
  logic [DATA_W-1:0] cnt_q;

  // without permission, counter writes may only clear bits
  always_ff @(posedge clk_i or negedge nv_rst_ni) begin
    if (!nv_rst_ni)     cnt_q <= '1;
    else if (restore_i) cnt_q <= '1;
    else if (cnt_wr_i)  cnt_q <= we_i ? data_i : (cnt_q & data_i);
  end
  assign cnt_o = cnt_q;

  for (genvar g = 0; g < NUM_CODE; g++) begin : g_code
    logic [DATA_W-1:0] byte_q;
    logic              prot_q;
    always_ff @(posedge clk_i or negedge nv_rst_ni) begin
      if (!nv_rst_ni) begin
        byte_q <= CODE_INIT[g*DATA_W +: DATA_W];
        prot_q <= 1'b0;
      end else if (code_wr_i[g] && we_i && !prot_q) begin
        byte_q <= data_i;
        if (code_prot_i) prot_q <= 1'b1;
      end
    end
    assign code_o[g] = byte_q;
  end
endmodule

// File: rtl/sec_verify_ctrl.sv
module sec_verify_ctrl #(
  parameter int DATA_W   = 8,
  parameter int NUM_CODE = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cnt_wr_i,
  input  logic [DATA_W-1:0]               data_i,
  input  logic [DATA_W-1:0]               cnt_i,
  input  logic [NUM_CODE-1:0]             vfy_sel_i,
  input  logic [NUM_CODE-1:0][DATA_W-1:0] code_i,
  output logic                            we_o,
  output logic                            armed_o,
  output logic                            restore_o
);
  localparam int STG_W = (NUM_CODE > 1) ? $clog2(NUM_CODE) : 1;
  localparam logic [STG_W-1:0] LAST = STG_W'(NUM_CODE - 1);

  logic              we_q, armed_q;
  logic [STG_W-1:0]  stage_q;
  logic              hit, vfy_go, byte_ok, arm_set;
  logic [STG_W-1:0]  idx;
  logic [DATA_W-1:0] code_sel;

  always_comb begin
    hit      = 1'b0;
    idx      = '0;
    code_sel = '0;
    for (int k = 0; k < NUM_CODE; k++) begin
      if (vfy_sel_i[k]) begin
        hit      = 1'b1;
        idx      = STG_W'(k);
        code_sel = code_i[k];
      end
    end
  end

  assign vfy_go    = hit && armed_q && !we_q;
  assign byte_ok   = (idx == stage_q) && (data_i == code_sel);
  assign restore_o = vfy_go && byte_ok && (idx == LAST);
  // an attempt is paid for by clearing at least one set counter bit
  assign arm_set   = cnt_wr_i && !we_q && ((cnt_i & data_i) != cnt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      armed_q <= 1'b0;
      stage_q <= '0;
    end else if (restore_o) begin
      we_q    <= 1'b1;
      armed_q <= 1'b0;
      stage_q <= '0;
    end else if (vfy_go) begin
      if (byte_ok) begin
        stage_q <= stage_q + 1'b1;
      end else begin
        armed_q <= 1'b0;
        stage_q <= '0;
      end
    end else if (arm_set) begin
      armed_q <= 1'b1;
    end
  end

  assign we_o    = we_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/sec_code_guard.sv
module sec_code_guard
  import sec_pkg::*;
#(
  parameter int                         ADDR_W    = 10,
  parameter int                         DATA_W    = 8,
  parameter int                         NUM_CODE  = 2,
  parameter logic [NUM_CODE*DATA_W-1:0] CODE_INIT = 16'hA55A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nv_rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              wr_en_o,
  output logic              locked_o,
  output logic [DATA_W-1:0] err_cnt_o
);
  logic                            cnt_wr, code_prot, we, armed, restore;
  logic [NUM_CODE-1:0]             vfy_sel, code_wr;
  logic [DATA_W-1:0]               cnt;
  logic [NUM_CODE-1:0][DATA_W-1:0] code;

  sec_cmd_decode #(.ADDR_W(ADDR_W), .NUM_CODE(NUM_CODE)) u_dec (
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_addr_i  (cmd_addr_i),
    .cnt_wr_o    (cnt_wr),
    .vfy_sel_o   (vfy_sel),
    .code_wr_o   (code_wr),
    .code_prot_o (code_prot)
  );

  sec_nv_store #(.DATA_W(DATA_W), .NUM_CODE(NUM_CODE), .CODE_INIT(CODE_INIT)) u_store (
    .clk_i       (clk_i),
    .nv_rst_ni   (nv_rst_ni),
    .we_i        (we),
    .restore_i   (restore),
    .cnt_wr_i    (cnt_wr),
    .code_wr_i   (code_wr),
    .code_prot_i (code_prot),
    .data_i      (cmd_data_i),
    .cnt_o       (cnt),
    .code_o      (code)
  );

  sec_verify_ctrl #(.DATA_W(DATA_W), .NUM_CODE(NUM_CODE)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_wr_i  (cnt_wr),
    .data_i    (cmd_data_i),
    .cnt_i     (cnt),
    .vfy_sel_i (vfy_sel),
    .code_i    (code),
    .we_o      (we),
    .armed_o   (armed),
    .restore_o (restore)
  );

  assign wr_en_o   = we;
  assign err_cnt_o = cnt;
  assign locked_o  = (cnt == '0) && !armed && !we;
endmodule

// File: rtl/sec_code_guard_chk.sv
module sec_code_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              nv_rst_ni,
  input logic              wr_en_o,
  input logic              locked_o,
  input logic [DATA_W-1:0] err_cnt_o
);
  AST_WE_LOW_IN_RST: assert property (@(posedge clk_i)
    !rst_ni |-> !wr_en_o); // R1

  AST_CNT_ONLY_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni || !nv_rst_ni)
    !wr_en_o |-> ((err_cnt_o & ~$past(err_cnt_o)) == '0)); // R3

  AST_UNLOCK_REFILLS: assert property (@(posedge clk_i) disable iff (!rst_ni || !nv_rst_ni)
    $rose(wr_en_o) |-> (err_cnt_o == '1)); // R5

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!nv_rst_ni)
    locked_o |=> locked_o); // R7

  AST_NO_UNLOCK_FROM_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni || !nv_rst_ni)
    $rose(wr_en_o) |-> !$past(locked_o)); // R7

  AST_WE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni || !nv_rst_ni)
    wr_en_o |=> wr_en_o); // R11
endmodule

bind sec_code_guard sec_code_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .nv_rst_ni (nv_rst_ni),
  .wr_en_o   (wr_en_o),
  .locked_o  (locked_o),
  .err_cnt_o (err_cnt_o)
);

// File: tb/sec_code_guard_test.sv
`timescale 1ns/1ps
module sec_code_guard_test;
  localparam logic [9:0] A_CNT = 10'h3FD;
  localparam logic [9:0] A_C0  = 10'h3FE;
  localparam logic [9:0] A_C1  = 10'h3FF;
  localparam logic [7:0] INIT0 = 8'h5A;
  localparam logic [7:0] INIT1 = 8'hA5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0, nv_rst_ni = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [1:0] cmd_op_i = 2'd3;
  logic [9:0] cmd_addr_i = '0;
  logic [7:0] cmd_data_i = '0;
  logic       wr_en_o, locked_o;
  logic [7:0] err_cnt_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [7:0] m_cnt;
  logic [7:0] m_code [2];
  bit         m_prot [2];
  bit         m_arm, m_we;
  int         m_stage;

  always #2.5 clk_i = ~clk_i;

  sec_code_guard uut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_locked();
    return (m_cnt == 8'h00) && !m_arm && !m_we;
  endfunction

  task automatic chk_all(input string tag);
    chk(tag, "wr_en_o", int'(wr_en_o), int'(m_we));
    chk(tag, "locked_o", int'(locked_o), int'(exp_locked()));
    chk(tag, "err_cnt_o", int'(err_cnt_o), int'(m_cnt));
  endtask

  task automatic model_cmd(input logic [1:0] op, input logic [9:0] a, input logic [7:0] d,
                           output string tag);
    int ci;
    ci  = (a == A_C0) ? 0 : (a == A_C1) ? 1 : -1;
    tag = "R10";
    if (op == 2'd1 || op == 2'd2) begin
      if (a == A_CNT) begin
        if (m_we) begin
          m_cnt = d; tag = "R8";
        end else begin
          if ((m_cnt & d) != m_cnt) m_arm = 1;
          m_cnt = m_cnt & d; tag = "R3";
        end
      end else if (ci >= 0) begin
        tag = "R9";
        if (m_we && !m_prot[ci]) begin
          m_code[ci] = d;
          if (op == 2'd2) m_prot[ci] = 1;
        end
      end
    end else if (op == 2'd0 && ci >= 0) begin
      if (m_we) tag = "R11";
      else if (!m_arm) tag = (m_cnt == 0) ? "R7" : "R4";
      else if (ci == m_stage && d == m_code[ci]) begin
        tag = "R5";
        if (ci == 1) begin
          m_we = 1; m_cnt = 8'hFF; m_arm = 0; m_stage = 0;
        end else m_stage = 1;
      end else begin
        m_arm = 0; m_stage = 0; tag = "R6";
      end
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [9:0] a, input logic [7:0] d);
    string tag;
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a; cmd_data_i = d;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; cmd_op_i = 2'd3;
    model_cmd(op, a, d, tag);
    chk_all(tag);
  endtask

  task automatic do_reset(input bit nv);
    @(negedge clk_i);
    rst_ni = 1'b0;
    if (nv) nv_rst_ni = 1'b0;
    @(negedge clk_i);
    m_we = 0; m_arm = 0; m_stage = 0;
    if (nv) begin
      m_cnt = 8'hFF; m_code[0] = INIT0; m_code[1] = INIT1; m_prot[0] = 0; m_prot[1] = 0;
    end
    chk_all(nv ? "R2" : "R1");
    @(negedge clk_i);
    rst_ni = 1'b1; nv_rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all(nv ? "R2" : "R1");
  endtask

  // clear lowest set bit of the modelled counter
  function automatic logic [7:0] spend();
    return m_cnt & (m_cnt - 8'd1);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EC0_0DE1));
    do_reset(1);

    // R4: verify without a paid attempt is ignored
    do_cmd(2'd0, A_C0, INIT0);
    do_cmd(2'd0, A_C1, INIT1);
    // R3, R5: pay, then unlock
    do_cmd(2'd1, A_CNT, 8'hFE);
    do_cmd(2'd0, A_C0, INIT0);
    do_cmd(2'd0, A_C1, INIT1);
    // R11: wrong verify while enabled
    do_cmd(2'd0, A_C0, 8'h00);
    // R8: free counter writes while enabled
    do_cmd(2'd1, A_CNT, 8'h00);
    do_cmd(2'd2, A_CNT, 8'hFF);
    // R10: other addresses and no-op
    do_cmd(2'd1, 10'h010, 8'h00);
    do_cmd(2'd3, A_CNT, 8'h00);
    do_cmd(2'd0, A_CNT, 8'h00);
    // R9: rewrite codes, protect byte 1, protected rewrite ignored
    do_cmd(2'd1, A_C0, 8'h33);
    do_cmd(2'd2, A_C1, 8'h44);
    do_cmd(2'd1, A_C1, 8'h55);
    do_reset(0);
    do_cmd(2'd1, A_C0, 8'h77);   // R9: ignored without permission
    do_cmd(2'd1, A_CNT, spend());
    do_cmd(2'd0, A_C0, 8'h33);
    do_cmd(2'd0, A_C1, 8'h44);   // R9 observed as unlock
    // R6: mismatch ends attempt; correct bytes afterwards ignored
    do_reset(0);
    do_cmd(2'd1, A_CNT, spend());
    do_cmd(2'd0, A_C0, 8'h34);
    do_cmd(2'd0, A_C0, 8'h33);
    do_cmd(2'd0, A_C1, 8'h44);
    // R6: byte 1 before byte 0
    do_cmd(2'd1, A_CNT, spend());
    do_cmd(2'd0, A_C1, 8'h44);
    do_cmd(2'd0, A_C0, 8'h33);
    do_cmd(2'd0, A_C1, 8'h44);

    // R7: eight failures lock for good
    do_reset(1);
    for (int i = 0; i < 8; i++) begin
      do_cmd(2'd1, A_CNT, spend());
      do_cmd(2'd0, A_C0, ~INIT0);
    end
    chk("R7", "locked after eight", int'(locked_o), 1);
    do_cmd(2'd1, A_CNT, 8'hFF);
    do_cmd(2'd0, A_C0, INIT0);
    do_cmd(2'd0, A_C1, INIT1);
    do_reset(0);
    chk("R7", "locked after session reset", int'(locked_o), 1);

    // R7: last attempt can still succeed
    do_reset(1);
    for (int i = 0; i < 7; i++) begin
      do_cmd(2'd1, A_CNT, spend());
      do_cmd(2'd0, A_C1, INIT1);
    end
    do_cmd(2'd1, A_CNT, spend());
    do_cmd(2'd0, A_C0, INIT0);
    do_cmd(2'd0, A_C1, INIT1);
    chk("R7", "last attempt unlock", int'(wr_en_o), 1);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [1:0] op;
      logic [9:0] a;
      logic [7:0] d;
      int r;
      if (n % 600 == 599) do_reset(1);
      else if (n % 150 == 149) do_reset(0);
      r = $urandom_range(0, 7);
      a = (r < 3) ? A_CNT : (r < 5) ? A_C0 : (r < 7) ? A_C1 : 10'($urandom_range(0, 1020));
      r = $urandom_range(0, 9);
      op = (r < 5) ? 2'd0 : (r < 8) ? 2'd1 : (r < 9) ? 2'd2 : 2'd3;
      d = 8'($urandom);
      if (a == A_CNT && $urandom_range(0, 3) != 0) d = spend();
      if (a == A_C0 && $urandom_range(0, 9) < 7) d = m_code[0];
      if (a == A_C1 && $urandom_range(0, 9) < 7) d = m_code[1];
      do_cmd(op, a, d);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule